// File: doc/BRIEF.md
# Eight-Slot TDM Audio Deserializer

This block takes a serial audio stream on a single data line and turns it into parallel channel samples. The stream is sampled on the rising edge of the bit clock. A frame starts at the first bit clock edge where the frame-sync line is seen high after being low. In the multi-slot format a frame carries eight channels, one after another. Each channel has a 32-clock slot that holds a 24-bit word, sent MSB first at the start of the slot and followed by padding. Two two-channel formats are also decoded: one aligned to the frame-sync edge, and one with the word delayed by one clock. A format code selects the framing.

When a frame completes, all channel samples are copied into the output registers together and a one-cycle valid strobe is raised. A serial source cannot be paused, so the output side has no ready input and applies no back-pressure. The consumer must take `ch_data` in the cycle where `ch_valid` is high. The data stays stable until the next completed frame overwrites it. Malformed framing raises a one-cycle `frame_err` pulse. The reserved format code drives `fmt_err` high and keeps the outputs silent.

Top module: `tdm_deser`

## Requirements
- R1: While `rst` is high at a clock edge, `ch_data` becomes zero and `ch_valid`, `frame_err` and `fmt_err` become low.
- R2: With `fmt_sel` = 2'b10, a frame lasts 256 clocks, counted from frame-start edge 0. Channel k (k = 1..8) is the MSB-first 24-bit word at edges 32(k-1) to 32(k-1)+23, and it appears on `ch_data[24(k-1) +: 24]`.
- R3: The 8 padding bits at the end of every slot, and the unused edge 0 in the delayed two-channel format, never reach any sample.
- R4: `ch_valid` is high for exactly one cycle, starting right after the edge that samples the frame's last bit (edge 255, or edge 63 in the two-channel formats). All channels update in that same cycle.
- R5: With `fmt_sel` = 2'b00, a frame lasts 64 clocks. Channel 1 MSB is at edge 0 and channel 2 MSB is at edge 32. Channels 3 to 8 output zero.
- R6: With `fmt_sel` = 2'b01, the layout is as in R5 but delayed by one clock: channel 1 MSB is at edge 1 and channel 2 MSB is at edge 33.
- R7: A frame-sync rise before the current frame has ended pulses `frame_err` for one cycle. The partial frame is never output, and the rising edge starts a new frame.
- R8: If the edge after a frame's last bit shows no frame-sync rise, `frame_err` pulses once. No further error is raised while waiting for the next rise.
- R9: While `fmt_sel` = 2'b11, `fmt_err` is high from the next cycle, `ch_data` is zero, and no valid strobe or frame error is produced. After a legal code returns, `fmt_err` drops and capture restarts at the next frame-sync rise.
- R10: The format is sampled at the frame-start edge. Changes on `fmt_sel` during a frame (other than to 2'b11) do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Bit clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frame_sync | input | 1 | Frame sync; a low-to-high change marks frame start |
| sd_in | input | 1 | Serial audio data |
| fmt_sel | input | 2 | 00 two-channel aligned, 01 two-channel delayed, 10 eight-slot, 11 reserved |
| ch_data | output | 192 | Eight 24-bit samples, channel 1 in the low bits |
| ch_valid | output | 1 | One-cycle strobe when a new frame of samples is loaded |
| frame_err | output | 1 | One-cycle pulse for an early or missing frame sync |
| fmt_err | output | 1 | High while the reserved format code is selected |

## Verification
The hardest cases to reach from the ports are frames that break partway through: a frame-sync rise 100 bits into an eight-slot frame, and a format change during a frame that must not take effect. The driver produces each frame bit by bit from a position counter. It can stop early, or change `fmt_sel` at a chosen bit, and it only queues frames that run to completion. An aborted frame that leaked to the output would therefore fail against the next queued entry. Padding bits and the idle first bit of the delayed format are driven as ones, so any leak into a sample shows up as a mismatch.

// File: rtl/tdm_deser_pkg.sv
package tdm_deser_pkg;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_TDM = 2'b10,
    FMT_RSV = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_WAIT = 2'b10
  } fr_st_e;

endpackage

// File: rtl/tdm_framer.sv
module tdm_framer
  import tdm_deser_pkg::*;
#(
  parameter int N_SLOT   = 8,
  parameter int SLOT_LEN = 32,
  parameter int N_PAIR   = 2,
  parameter int POS_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fs_in,
  input  logic [1:0]       fmt_in,
  output logic             rsv_o,
  output logic             cap_en_o,
  output logic [POS_W-1:0] pos_o,
  output fmt_e             mode_o,
  output logic             done_o,
  output logic             err_o
);

  localparam logic [POS_W-1:0] TDM_LAST  = POS_W'(N_SLOT * SLOT_LEN - 1);
  localparam logic [POS_W-1:0] PAIR_LAST = POS_W'(N_PAIR * SLOT_LEN - 1);

  fr_st_e           st_q;
  logic [POS_W-1:0] cnt_q;
  fmt_e             mode_q;
  logic             fs_q;
  logic             err_q;

  logic             rise;
  logic             rsv;
  fmt_e             mode_now;
  logic [POS_W-1:0] pos_now;
  logic [POS_W-1:0] last_pos;
  logic             act;
  logic             done_now;
  logic             early;
  logic             late;

  always_comb begin
    rise     = fs_in & ~fs_q;
    rsv      = (fmt_in == 2'b11);
    mode_now = rise ? fmt_e'(fmt_in) : mode_q;
    pos_now  = rise ? '0 : cnt_q;
    last_pos = (mode_now == FMT_TDM) ? TDM_LAST : PAIR_LAST;
    act      = !rsv && (rise || (st_q == ST_RUN));
    done_now = act && (pos_now == last_pos);
    early    = !rsv && rise && (st_q == ST_RUN);
    late     = !rsv && !rise && (st_q == ST_WAIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      mode_q <= FMT_TDM;
      fs_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      fs_q  <= fs_in;
      err_q <= early | late;
      if (rsv) begin
        st_q  <= ST_IDLE;
        cnt_q <= '0;
      end else begin
        mode_q <= mode_now;
        if (done_now) begin
          st_q  <= ST_WAIT;
          cnt_q <= '0;
        end else if (act) begin
          st_q  <= ST_RUN;
          cnt_q <= pos_now + POS_W'(1);
        end else if (st_q == ST_WAIT) begin
          st_q  <= ST_IDLE;
        end
      end
    end
  end

  assign rsv_o    = rsv;
  assign cap_en_o = act;
  assign pos_o    = pos_now;
  assign mode_o   = mode_now;
  assign done_o   = done_now;
  assign err_o    = err_q;

  // R2
  cnt_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN) |-> ((cnt_q != '0) && ((mode_q == FMT_TDM) || (cnt_q <= PAIR_LAST))));

  // R8
  wait_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT) |-> $past(done_now));

endmodule

// File: rtl/tdm_capture.sv
module tdm_capture
  import tdm_deser_pkg::*;
#(
  parameter int N_SLOT   = 8,
  parameter int SLOT_LEN = 32,
  parameter int SAMP_W   = 24,
  parameter int N_PAIR   = 2,
  parameter int POS_W    = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cap_en,
  input  logic [POS_W-1:0]         pos,
  input  fmt_e                     mode,
  input  logic                     sd_in,
  output logic [N_SLOT*SAMP_W-1:0] shadow_o
);

  localparam int SL_W = $clog2(SLOT_LEN);
  localparam int SI_W = POS_W - SL_W;

  logic [N_SLOT-1:0][SAMP_W-1:0] sh_q;
  logic [POS_W-1:0]              off;
  logic [SI_W-1:0]               slot_idx;
  logic [SL_W-1:0]               bit_idx;
  logic                          skip;
  logic                          wr;

  always_comb begin
    off      = (mode == FMT_I2S) ? (pos - POS_W'(1)) : pos;
    skip     = (mode == FMT_I2S) && (pos == '0);
    slot_idx = off[POS_W-1:SL_W];
    bit_idx  = off[SL_W-1:0];
    wr       = cap_en && !skip && ({1'b0, bit_idx} < (SL_W+1)'(SAMP_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else if (wr) begin
      for (int g = 0; g < N_SLOT; g++) begin
        for (int b = 0; b < SAMP_W; b++) begin
          if ((slot_idx == SI_W'(g)) && (bit_idx == SL_W'(SAMP_W - 1 - b)))
            sh_q[g][b] <= sd_in;
        end
      end
    end
  end

  assign shadow_o = sh_q;

  // R5
  pair_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && (mode != FMT_TDM)) |-> (slot_idx < SI_W'(N_PAIR)));

  // R3
  pad_never_written_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_en && !skip && ({1'b0, bit_idx} >= (SL_W+1)'(SAMP_W))) |=> $stable(sh_q));

endmodule

// File: rtl/tdm_outreg.sv
module tdm_outreg
  import tdm_deser_pkg::*;
#(
  parameter int N_SLOT = 8,
  parameter int SAMP_W = 24,
  parameter int N_PAIR = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rsv,
  input  logic                     done,
  input  fmt_e                     mode,
  input  logic [N_SLOT*SAMP_W-1:0] shadow_i,
  output logic [N_SLOT*SAMP_W-1:0] data_o,
  output logic                     valid_o,
  output logic                     fmt_err_o
);

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    logic [SAMP_W-1:0] q;
    if (g < N_PAIR) begin : g_any_fmt
      always_ff @(posedge clk) begin
        if (rst || rsv)
          q <= '0;
        else if (done)
          q <= shadow_i[g*SAMP_W +: SAMP_W];
      end
    end else begin : g_tdm_only
      always_ff @(posedge clk) begin
        if (rst || rsv)
          q <= '0;
        else if (done)
          q <= (mode == FMT_TDM) ? shadow_i[g*SAMP_W +: SAMP_W] : '0;
      end
    end
    assign data_o[g*SAMP_W +: SAMP_W] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o   <= 1'b0;
      fmt_err_o <= 1'b0;
    end else begin
      valid_o   <= done && !rsv;
      fmt_err_o <= rsv;
    end
  end

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R9
  rsv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    fmt_err_o |-> ((data_o == '0) && !valid_o));

endmodule

// File: rtl/tdm_deser.sv
module tdm_deser
  import tdm_deser_pkg::*;
#(
  parameter int N_SLOT   = 8,
  parameter int SLOT_LEN = 32,
  parameter int SAMP_W   = 24,
  parameter int N_PAIR   = 2
) (
  input  logic                     sclk,
  input  logic                     rst,
  input  logic                     frame_sync,
  input  logic                     sd_in,
  input  logic [1:0]               fmt_sel,
  output logic [N_SLOT*SAMP_W-1:0] ch_data,
  output logic                     ch_valid,
  output logic                     frame_err,
  output logic                     fmt_err
);

  localparam int FRAME_LEN = N_SLOT * SLOT_LEN;
  localparam int POS_W     = $clog2(FRAME_LEN);

  logic                     rsv;
  logic                     cap_en;
  logic [POS_W-1:0]         pos;
  fmt_e                     mode;
  logic                     done;
  logic [N_SLOT*SAMP_W-1:0] shadow;

  tdm_framer #(
    .N_SLOT(N_SLOT), .SLOT_LEN(SLOT_LEN), .N_PAIR(N_PAIR), .POS_W(POS_W)
  ) u_framer (
    .clk(sclk), .rst(rst), .fs_in(frame_sync), .fmt_in(fmt_sel),
    .rsv_o(rsv), .cap_en_o(cap_en), .pos_o(pos), .mode_o(mode),
    .done_o(done), .err_o(frame_err)
  );

  tdm_capture #(
    .N_SLOT(N_SLOT), .SLOT_LEN(SLOT_LEN), .SAMP_W(SAMP_W), .N_PAIR(N_PAIR), .POS_W(POS_W)
  ) u_capture (
    .clk(sclk), .rst(rst), .cap_en(cap_en), .pos(pos), .mode(mode),
    .sd_in(sd_in), .shadow_o(shadow)
  );

  tdm_outreg #(
    .N_SLOT(N_SLOT), .SAMP_W(SAMP_W), .N_PAIR(N_PAIR)
  ) u_outreg (
    .clk(sclk), .rst(rst), .rsv(rsv), .done(done), .mode(mode),
    .shadow_i(shadow), .data_o(ch_data), .valid_o(ch_valid), .fmt_err_o(fmt_err)
  );

  // R7
  err_valid_excl_chk: assert property (@(posedge sclk) disable iff (rst)
    !(ch_valid && frame_err));

  // R9
  rsv_no_frame_err_chk: assert property (@(posedge sclk) disable iff (rst)
    (fmt_err && $past(fmt_err)) |-> !frame_err);

endmodule

// File: tb/tb_tdm_deser.sv
`timescale 1ns/1ps
module tb_tdm_deser;

  logic         sclk = 1'b0;
  logic         rst = 1'b1;
  logic         frame_sync = 1'b0;
  logic         sd_in = 1'b0;
  logic [1:0]   fmt_sel = 2'b10;
  logic [191:0] ch_data;
  logic         ch_valid;
  logic         frame_err;
  logic         fmt_err;

  int total = 0;
  int bad = 0;
  int err_seen = 0;
  logic prev_v = 1'b0;
  logic [191:0] exp_q[$];
  string tag_q[$];
  logic [191:0] mon_e;
  string mon_t;

  always #2.5 sclk = ~sclk;

  tdm_deser dut (
    .sclk(sclk), .rst(rst), .frame_sync(frame_sync), .sd_in(sd_in), .fmt_sel(fmt_sel),
    .ch_data(ch_data), .ch_valid(ch_valid), .frame_err(frame_err), .fmt_err(fmt_err)
  );

  task automatic chk(input string tag, input logic [191:0] act, input logic [191:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected frames as valid strobes appear
  always @(posedge sclk) begin
    #1;
    if (!rst) begin
      if (ch_valid) begin
        if (prev_v) chk("R4 valid held longer than one cycle", 192'd1, 192'd0);
        if (exp_q.size() == 0) begin
          chk("R4/R7 valid with no complete frame pending", 192'd1, 192'd0);
        end else begin
          mon_e = exp_q.pop_front();
          mon_t = tag_q.pop_front();
          chk(mon_t, ch_data, mon_e);
        end
      end
      if (frame_err) err_seen++;
      prev_v = ch_valid;
    end
  end

  function automatic logic [191:0] mkpat(input int seed);
    logic [191:0] d;
    for (int c = 0; c < 8; c++)
      d[c*24 +: 24] = 24'(seed * 32'h9E3779 + c * 32'h010307) ^ 24'hA5C35A;
    return d;
  endfunction

  function automatic logic bitval(input logic [1:0] f, input logic [191:0] d, input int p);
    int q;
    int slot;
    int b;
    q = p - ((f == 2'b01) ? 1 : 0);
    if (q < 0) return 1'b1;
    slot = q / 32;
    b = q % 32;
    if (b >= 24) return 1'b1;
    if (f != 2'b10 && slot >= 2) return 1'b1;
    return d[slot*24 + 23 - b];
  endfunction

  task automatic send_frame(input logic [1:0] f, input logic [191:0] d, input int nbits,
                            input int chg_at, input logic [1:0] chg_fmt, input string tag);
    int len;
    logic [191:0] e;
    len = (f == 2'b10) ? 256 : 64;
    if (nbits >= len) begin
      e = d;
      if (f != 2'b10) e[191:48] = '0;
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    for (int p = 0; p < nbits && p < len; p++) begin
      @(negedge sclk);
      frame_sync = (p == 0);
      fmt_sel = (chg_at >= 0 && p >= chg_at) ? chg_fmt : f;
      sd_in = bitval(f, d, p);
    end
    if (nbits >= len) begin
      @(posedge sclk);
      #1;
      chk("R4 valid right after last bit", {191'd0, ch_valid}, 192'd1);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge sclk);
      frame_sync = 1'b0;
      sd_in = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge sclk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e0;
    repeat (4) @(negedge sclk);
    // R1 reset state
    chk("R1 data in reset", ch_data, 192'd0);
    chk("R1 flags in reset", {189'd0, ch_valid, frame_err, fmt_err}, 192'd0);
    rst = 1'b0;
    idle(3);

    // R2 R3 eight-slot frames back to back
    e0 = err_seen;
    send_frame(2'b10, mkpat(1), 256, -1, 2'b10, "R2 tdm frame 1");
    send_frame(2'b10, mkpat(2), 256, -1, 2'b10, "R2 tdm frame 2");
    send_frame(2'b10, ~mkpat(3), 256, -1, 2'b10, "R3 tdm frame 3 padding ones");
    idle(6);
    chk("R8 one late-sync error after tdm run", 192'(err_seen - e0), 192'd1);
    idle(20);
    chk("R8 no repeat error while waiting", 192'(err_seen - e0), 192'd1);

    // R5 two-channel aligned
    e0 = err_seen;
    send_frame(2'b00, mkpat(4), 256, -1, 2'b00, "R5 aligned frame 1");
    send_frame(2'b00, mkpat(5), 256, -1, 2'b00, "R5 aligned frame 2");
    idle(4);
    chk("R8 late error after aligned run", 192'(err_seen - e0), 192'd1);

    // R6 two-channel delayed
    e0 = err_seen;
    send_frame(2'b01, mkpat(6), 256, -1, 2'b01, "R6 delayed frame 1");
    send_frame(2'b01, ~mkpat(7), 256, -1, 2'b01, "R6 delayed frame 2");
    idle(4);
    chk("R8 late error after delayed run", 192'(err_seen - e0), 192'd1);

    // R7 early frame sync
    e0 = err_seen;
    send_frame(2'b10, mkpat(8), 100, -1, 2'b10, "R7 partial");
    send_frame(2'b10, mkpat(9), 256, -1, 2'b10, "R7 frame after early sync");
    idle(4);
    chk("R7 early plus late errors", 192'(err_seen - e0), 192'd2);
    chk("R7 queue drained, partial never output", 192'(exp_q.size()), 192'd0);

    // R10 format change mid-frame
    send_frame(2'b10, mkpat(10), 256, 50, 2'b00, "R10 format latched at start");
    idle(4);

    // R9 reserved code
    e0 = err_seen;
    @(negedge sclk);
    fmt_sel = 2'b11;
    for (int i = 0; i < 3; i++) begin
      @(negedge sclk); frame_sync = 1'b1;
      @(negedge sclk); frame_sync = 1'b0;
      idle(3);
    end
    chk("R9 fmt_err high", {191'd0, fmt_err}, 192'd1);
    chk("R9 data zero", ch_data, 192'd0);
    chk("R9 no frame errors", 192'(err_seen - e0), 192'd0);
    @(negedge sclk);
    fmt_sel = 2'b10;
    idle(2);
    chk("R9 fmt_err clears", {191'd0, fmt_err}, 192'd0);
    send_frame(2'b10, mkpat(11), 256, -1, 2'b10, "R9 capture resumes");
    idle(4);
    chk("R2 all expected frames seen", 192'(exp_q.size()), 192'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule